// File: doc/BRIEF.md
# Cache Touch Prefetch Filter

This block sits at the front of the data cache and settles what happens to a software prefetch hint. A hint arrives as a plain touch or as a touch-for-store, together with the translation result, the protection check, the page attributes, the cache lock and enable state, a global hint-disable bit and the result of the cache lookup. The block drops the hint, finishes it as a hit, or starts a line fill with intent to modify.

A hint is never allowed to raise an exception. Every condition that would stop a load, and every condition that makes a fill unwanted, turns the hint into a silent one-cycle completion. When the hint survives and the lookup misses, the block asks the bus side for a fill and then waits for the acknowledge. Until that acknowledge arrives it reports busy and accepts nothing new. The acknowledge validates the filled line in the same way as a load fill.

Top module: `touch_filter`

## Requirements
- R1: After reset, busy, fill_req_mod, ref_set, fill_valid and done are 0 and hint_ready is 1.
- R2: An accepted hint with xlat_hit=0 is dropped. A dropped hint pulses done for one cycle, in the cycle after acceptance, with ref_set=0 and fill_req_mod=0.
- R3: An accepted hint with prot_ok=0 is dropped as in R2. No other output reports the failure.
- R4: An accepted hint with any of pg_inhibit, pg_guard or pg_direct set to 1 is dropped as in R2.
- R5: An accepted hint with cache_locked=1 or cache_on=0 is dropped as in R2.
- R6: With noop_ctl=1 every accepted hint is dropped as in R2, whatever the lookup result, so it finishes in one cycle with no fill request.
- R7: A surviving hint whose lookup hits (lookup_hit=1) pulses done and ref_set together in the cycle after acceptance and never raises fill_req_mod.
- R8: A surviving hint whose lookup misses raises fill_req_mod and busy in the cycle after acceptance, and pulses ref_set in that same cycle. done stays 0.
- R9: While busy=1, hint_ready is 0, incoming hints are ignored, and fill_req_mod stays 1 until fill_ack is sampled.
- R10: fill_ack sampled while busy=1 gives, in the next cycle, a one-cycle pulse on done and fill_valid, with busy and fill_req_mod back at 0.
- R11: hint_store has no effect. A touch-for-store gets exactly the outcome of a plain touch under the same conditions.
- R12: fill_ack while idle is ignored. It produces no done and no fill_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_valid | input | 1 | Prefetch hint presented |
| hint_store | input | 1 | 1 = touch-for-store, 0 = touch |
| xlat_hit | input | 1 | A valid translation was found |
| prot_ok | input | 1 | The load-style protection check passed |
| pg_inhibit | input | 1 | Page is cache-inhibited |
| pg_guard | input | 1 | Page is guarded |
| pg_direct | input | 1 | Page is a direct-store segment |
| cache_locked | input | 1 | Data cache is locked |
| cache_on | input | 1 | Data cache is enabled |
| noop_ctl | input | 1 | Global hint disable, 0 after reset |
| lookup_hit | input | 1 | Cache lookup hit for the hint address |
| fill_ack | input | 1 | Bus side has completed the fill |
| hint_ready | output | 1 | Block can accept a hint |
| busy | output | 1 | A fill is outstanding |
| fill_req_mod | output | 1 | Line fill request with intent to modify |
| ref_set | output | 1 | One-cycle strobe that sets the reference bit |
| fill_valid | output | 1 | One-cycle strobe that validates the filled line as a load fill |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions check on every cycle that each drop cause yields done with no reference strobe and no fill, and that a pending fill holds until its acknowledge. They also check that the acknowledge yields the completion and validation pulses and that ref_set never appears without a completion or a fill. Only the bench scenarios can show that a hint presented during a fill leaves no trace, that an idle acknowledge does nothing, and that the store variant matches the plain touch. The bench runs these over random mixes of conditions and fill latencies.

// File: rtl/touch_filter_pkg.sv
`timescale 1ns/1ps
package touch_filter_pkg;

  typedef enum logic [1:0] {
    TF_DROP = 2'd0,
    TF_HIT  = 2'd1,
    TF_MISS = 2'd2
  } tf_outcome_e;

  typedef struct packed {
    logic xlat_hit;
    logic prot_ok;
    logic pg_inhibit;
    logic pg_guard;
    logic pg_direct;
    logic cache_locked;
    logic cache_on;
    logic noop_ctl;
  } tf_cond_s;

  // Any reason that silences a hint.
  function automatic logic tf_is_drop(tf_cond_s c);
    logic bad_xlat, bad_page, bad_cache;
    bad_xlat  = !c.xlat_hit | !c.prot_ok;
    bad_page  = c.pg_inhibit | c.pg_guard | c.pg_direct;
    bad_cache = c.cache_locked | !c.cache_on;
    return c.noop_ctl | bad_xlat | bad_page | bad_cache;
  endfunction

  function automatic tf_outcome_e tf_classify(tf_cond_s c, logic hit);
    if (tf_is_drop(c)) return TF_DROP;
    else if (hit)      return TF_HIT;
    else               return TF_MISS;
  endfunction

endpackage

// File: rtl/touch_gate.sv
`timescale 1ns/1ps
module touch_gate
  import touch_filter_pkg::*;
(
  input  tf_cond_s    cond,
  input  logic        lookup_hit,
  output tf_outcome_e outcome
);
  always_comb outcome = tf_classify(cond, lookup_hit);
endmodule

// File: rtl/touch_seq.sv
`timescale 1ns/1ps
module touch_seq
  import touch_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  tf_outcome_e outcome,
  input  logic        fill_ack,
  output logic        busy,
  output logic        ref_set,
  output logic        fill_valid,
  output logic        done,
  output logic        ack_taken
);
  assign ack_taken = busy & fill_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      ref_set    <= 1'b0;
      fill_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      ref_set    <= 1'b0;
      fill_valid <= 1'b0;
      done       <= 1'b0;
      if (ack_taken) begin
        busy       <= 1'b0;
        done       <= 1'b1;
        fill_valid <= 1'b1;
      end else if (accept) begin
        done    <= (outcome != TF_MISS);
        ref_set <= (outcome != TF_DROP);
        busy    <= (outcome == TF_MISS);
      end
    end
  end
endmodule

// File: rtl/touch_filter.sv
`timescale 1ns/1ps
module touch_filter
  import touch_filter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hint_valid,
  input  logic hint_store,
  input  logic xlat_hit,
  input  logic prot_ok,
  input  logic pg_inhibit,
  input  logic pg_guard,
  input  logic pg_direct,
  input  logic cache_locked,
  input  logic cache_on,
  input  logic noop_ctl,
  input  logic lookup_hit,
  input  logic fill_ack,
  output logic hint_ready,
  output logic busy,
  output logic fill_req_mod,
  output logic ref_set,
  output logic fill_valid,
  output logic done
);
  tf_cond_s    cond;
  tf_outcome_e outcome;
  logic        accept;
  logic        ack_taken;
  logic        store_unused;

  // Both hint flavours share one path; the flavour bit selects nothing.
  assign store_unused = hint_store;

  always_comb begin
    cond.xlat_hit     = xlat_hit;
    cond.prot_ok      = prot_ok;
    cond.pg_inhibit   = pg_inhibit;
    cond.pg_guard     = pg_guard;
    cond.pg_direct    = pg_direct;
    cond.cache_locked = cache_locked;
    cond.cache_on     = cache_on;
    cond.noop_ctl     = noop_ctl;
  end

  assign hint_ready   = !busy;
  assign accept       = hint_valid & hint_ready;
  assign fill_req_mod = busy;

  touch_gate u_gate (
    .cond       (cond),
    .lookup_hit (lookup_hit),
    .outcome    (outcome)
  );

  touch_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .outcome    (outcome),
    .fill_ack   (fill_ack),
    .busy       (busy),
    .ref_set    (ref_set),
    .fill_valid (fill_valid),
    .done       (done),
    .ack_taken  (ack_taken)
  );
endmodule

// File: rtl/touch_filter_chk.sv
`timescale 1ns/1ps
module touch_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic xlat_hit,
  input logic prot_ok,
  input logic pg_inhibit,
  input logic pg_guard,
  input logic pg_direct,
  input logic cache_locked,
  input logic cache_on,
  input logic noop_ctl,
  input logic fill_ack,
  input logic busy,
  input logic fill_req_mod,
  input logic ref_set,
  input logic fill_valid,
  input logic done
);
  AST_NO_XLAT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !xlat_hit) |=> (done && !ref_set && !fill_req_mod)); // R2
  AST_PROT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !prot_ok) |=> (done && !ref_set && !fill_req_mod)); // R3
  AST_PAGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (pg_inhibit || pg_guard || pg_direct)) |=> (done && !ref_set && !fill_req_mod)); // R4
  AST_CACHE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cache_locked || !cache_on)) |=> (done && !ref_set && !fill_req_mod)); // R5
  AST_NOOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && noop_ctl) |=> (done && !busy && !ref_set)); // R6
  AST_REF_WITH_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    ref_set |-> (done || fill_req_mod)); // R7
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_mod && !fill_ack) |=> fill_req_mod); // R9
  AST_ACK_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_mod && fill_ack) |=> (done && fill_valid && !busy)); // R10
  AST_VALID_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(fill_req_mod)); // R12
endmodule

bind touch_filter touch_filter_chk u_chk (.*);

// File: tb/sim_touch_filter.sv
`timescale 1ns/1ps
module sim_touch_filter;
  logic clk = 1'b0;
  logic rst_n;
  logic hint_valid, hint_store, xlat_hit, prot_ok, pg_inhibit, pg_guard, pg_direct;
  logic cache_locked, cache_on, noop_ctl, lookup_hit, fill_ack;
  logic hint_ready, busy, fill_req_mod, ref_set, fill_valid, done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk; // 200 MHz

  touch_filter u0 (.*);

  task automatic chk(string req, logic act, logic exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp_v);
    end
  endtask

  // Bench view of the rules: 0 drop, 1 hit, 2 miss.
  function automatic int expect_kind(logic xh, logic po, logic ih, logic gd, logic ds,
                                     logic lk, logic en, logic nc, logic hit);
    if (nc) return 0;
    if (!(xh && po)) return 0;
    if ({ih, gd, ds} != 3'b000) return 0;
    if (lk || !en) return 0;
    return hit ? 1 : 2;
  endfunction

  task automatic idle_inputs();
    hint_valid = 0; hint_store = 0; xlat_hit = 1; prot_ok = 1; pg_inhibit = 0;
    pg_guard = 0; pg_direct = 0; cache_locked = 0; cache_on = 1; noop_ctl = 0;
    lookup_hit = 0; fill_ack = 0;
  endtask

  // Presents a hint at a negedge and checks the full outcome.
  task automatic run_hint(string req, logic st, logic xh, logic po, logic ih, logic gd,
                          logic ds, logic lk, logic en, logic nc, logic hit, int lat);
    int k;
    k = expect_kind(xh, po, ih, gd, ds, lk, en, nc, hit);
    @(negedge clk);
    hint_valid = 1; hint_store = st; xlat_hit = xh; prot_ok = po; pg_inhibit = ih;
    pg_guard = gd; pg_direct = ds; cache_locked = lk; cache_on = en; noop_ctl = nc;
    lookup_hit = hit;
    @(negedge clk);
    hint_valid = 0;
    chk(req, done, k != 2);
    chk(req, ref_set, k != 0);
    chk(req, fill_req_mod, k == 2);
    chk(req, busy, k == 2);
    if (k == 2) begin
      for (int i = 0; i < lat; i++) begin
        hint_valid = 1; lookup_hit = 1; // R9: must be ignored
        @(negedge clk);
        chk("R9", busy, 1'b1);
        chk("R9", hint_ready, 1'b0);
        chk("R9", done, 1'b0);
        chk("R9", ref_set, 1'b0);
      end
      hint_valid = 0;
      fill_ack = 1;
      @(negedge clk);
      fill_ack = 0;
      chk("R10", done, 1'b1);
      chk("R10", fill_valid, 1'b1);
      chk("R10", busy, 1'b0);
      chk("R10", fill_req_mod, 1'b0);
      @(negedge clk);
      chk("R10", done, 1'b0);
      chk("R10", fill_valid, 1'b0);
    end else begin
      @(negedge clk);
      chk(req, done, 1'b0);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", busy, 1'b0);
    chk("R1", fill_req_mod, 1'b0);
    chk("R1", done, 1'b0);
    chk("R1", ref_set, 1'b0);
    chk("R1", fill_valid, 1'b0);
    chk("R1", hint_ready, 1'b1);

    // Directed corners
    run_hint("R2", 0, 0,1,0,0,0,0,1,0, 0, 0);
    run_hint("R3", 0, 1,0,0,0,0,0,1,0, 0, 0);
    run_hint("R4", 0, 1,1,1,0,0,0,1,0, 0, 0);
    run_hint("R4", 0, 1,1,0,1,0,0,1,0, 0, 0);
    run_hint("R4", 0, 1,1,0,0,1,0,1,0, 0, 0);
    run_hint("R5", 0, 1,1,0,0,0,1,1,0, 0, 0);
    run_hint("R5", 0, 1,1,0,0,0,0,0,0, 0, 0);
    run_hint("R6", 0, 1,1,0,0,0,0,1,1, 1, 0);
    run_hint("R6", 0, 1,1,0,0,0,0,1,1, 0, 0);
    run_hint("R7", 0, 1,1,0,0,0,0,1,0, 1, 0);
    run_hint("R8", 0, 1,1,0,0,0,0,1,0, 0, 0);
    run_hint("R8", 0, 1,1,0,0,0,0,1,0, 0, 4);
    run_hint("R11", 1, 1,1,0,0,0,0,1,0, 0, 2);
    run_hint("R11", 1, 1,1,0,0,0,0,1,0, 1, 0);

    // R12: acknowledge while idle
    @(negedge clk);
    fill_ack = 1;
    @(negedge clk);
    fill_ack = 0;
    chk("R12", done, 1'b0);
    chk("R12", fill_valid, 1'b0);
    chk("R12", busy, 1'b0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      run_hint("R11", $urandom_range(1), ($urandom_range(7) != 0), ($urandom_range(7) != 0),
               ($urandom_range(9) == 0), ($urandom_range(9) == 0), ($urandom_range(9) == 0),
               ($urandom_range(9) == 0), ($urandom_range(9) != 0), ($urandom_range(9) == 0),
               $urandom_range(1), $urandom_range(5));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule